// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Replay

This block is a shared scratchpad memory for a group of 16 lanes. Each request carries one byte address, one write flag and one data word for every lane, and all 16 lanes are presented in the same cycle. The storage is split into 16 banks with one 32-bit word per bank in each row, so consecutive words fall in consecutive banks.

Each bank serves one word per cycle. When several lanes hit different words of the same bank, the block replays the group over extra cycles. Lanes that hit the same word share one bank access, so reads of one word are broadcast. While passes remain the block holds `busy` and takes no new request. After the last pass it pulses `done` once. At that point `rdata` holds the word read back for every lane.

A caller drives a request for one cycle while `busy` is low. It then waits for `done` and takes all lane results at once.

Top module: `banked_scratchpad`

## Requirements
- R1: Lane byte address bits [5:2] select the bank and bits [13:6] select the row in that bank; bits [1:0] are ignored, so every access moves a whole 32-bit word.
- R2: The group takes N pass cycles, where N is the largest number of distinct words that the group's lanes hit in any one bank (at least 1); `busy` is high for exactly those N cycles, starting the cycle after the request is taken.
- R3: A group whose 16 lanes hit 16 different banks finishes in one pass.
- R4: Any number of lanes reading one word are served in a single pass of that bank and all receive the same value.
- R5: Every lane, reading or writing, gets in its `rdata` field the contents its word had before the group was taken (a read and a write to one word in the same group return the old value).
- R6: When several lanes of a group write the same word, the data of the highest-numbered of those lanes is stored.
- R7: `req_valid` while `busy` is high is ignored: it neither writes memory nor changes the current group's timing.
- R8: `done` is high for exactly one cycle, the second cycle after the last pass cycle (the cycle after `busy` falls); in that cycle `rdata` holds all 16 lane results, lane l in bits [32l+31:32l].
- R9: After reset `busy` and `done` are low and `rdata` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe; taken when `busy` is low |
| req_we | input | 16 | Per-lane write flag, bit l for lane l |
| req_addr | input | 224 | Per-lane byte address, 14 bits per lane, lane l in bits [14l+13:14l] |
| req_wdata | input | 512 | Per-lane write data, lane l in bits [32l+31:32l] |
| busy | output | 1 | High while passes of the current group remain |
| done | output | 1 | One-cycle pulse when all lane results are valid |
| rdata | output | 512 | Per-lane read results, lane l in bits [32l+31:32l] |

## Verification
On every cycle, the assertions check these properties:
- an accepted request raises `busy` at once;
- every busy cycle serves at least one pending lane;
- a request seen while busy never reloads the lane set;
- the pass count stays within the lane count;
- `done` is a lone pulse that follows the fall of `busy` by one cycle.

The bench scenarios cover the things no assertion can see: the data itself, the exact pass count for each conflict pattern, broadcast sharing, write priority between lanes, old-value return, and the fact that ignored requests leave memory untouched.

// File: rtl/banked_scratchpad.sv
module banked_scratchpad #(
  parameter int LANES    = 16,
  parameter int ROW_BITS = 8,
  parameter int DW       = 32,
  localparam int BB      = $clog2(LANES),
  localparam int AW      = 2 + BB + ROW_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [LANES-1:0]    req_we,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [LANES*DW-1:0] req_wdata,
  output logic                busy,
  output logic                done,
  output logic [LANES*DW-1:0] rdata
);
  localparam int ROWS = 1 << ROW_BITS;
  localparam int CW   = $clog2(LANES + 2);

  logic [LANES-1:0]    pend, served, we_q, cap_en;
  logic [BB-1:0]       bank_q  [LANES];
  logic [BB-1:0]       cap_sel [LANES];
  logic [ROW_BITS-1:0] row_q   [LANES];
  logic [DW-1:0]       wd_q    [LANES];
  logic [ROW_BITS-1:0] srow    [LANES];
  logic [DW-1:0]       bwd     [LANES];
  logic [DW-1:0]       bq      [LANES];
  logic [LANES-1:0]    bwe;
  logic                fin_q;
  logic [CW-1:0]       pass_cnt;

  assign busy = |pend;
  wire accept = req_valid && !busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend <= '0;
    else if (accept) pend <= '1;
    else pend <= pend & ~served;

  always_ff @(posedge clk)
    if (accept) begin
      we_q <= req_we;
      for (int l = 0; l < LANES; l++) begin
        bank_q[l] <= req_addr[l*AW+2 +: BB];
        row_q[l]  <= req_addr[l*AW+2+BB +: ROW_BITS];
        wd_q[l]   <= req_wdata[l*DW +: DW];
      end
    end

  // lowest pending lane picks each bank's word; every pending lane on that word rides along
  always_comb begin
    bwe = '0;
    for (int b = 0; b < LANES; b++) begin
      srow[b] = '0;
      bwd[b]  = '0;
    end
    for (int l = LANES-1; l >= 0; l--)
      if (pend[l]) srow[bank_q[l]] = row_q[l];
    for (int l = 0; l < LANES; l++)
      served[l] = pend[l] && (srow[bank_q[l]] == row_q[l]);
    for (int l = 0; l < LANES; l++)
      if (served[l] && we_q[l]) begin
        bwe[bank_q[l]] = 1'b1;
        bwd[bank_q[l]] = wd_q[l];
      end
  end

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [DW-1:0] ram [ROWS];
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (busy) q <= ram[srow[b]];
      if (bwe[b]) ram[srow[b]] <= bwd[b];
    end
    assign bq[b] = q;
  end

  always_ff @(posedge clk)
    for (int l = 0; l < LANES; l++) cap_sel[l] <= bank_q[l];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cap_en <= '0;
      fin_q  <= 1'b0;
      done   <= 1'b0;
      rdata  <= '0;
    end else begin
      cap_en <= served;
      fin_q  <= busy && ((pend & ~served) == '0);
      done   <= fin_q;
      for (int l = 0; l < LANES; l++)
        if (cap_en[l]) rdata[l*DW +: DW] <= bq[cap_sel[l]];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pass_cnt <= '0;
    else if (busy) pass_cnt <= pass_cnt + 1'b1;
    else pass_cnt <= '0;

  a_r2_busy_starts: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy |=> busy);
  a_r2_progress: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> |served);
  a_r2_pass_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pass_cnt < CW'(LANES));
  a_r7_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    busy && req_valid |=> $countones(pend) < $past($countones(pend)));
  a_r8_done_after: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !$past(busy) && $past(busy, 2));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/banked_scratchpad_test.sv
`timescale 1ns/1ps
module banked_scratchpad_test;
  localparam int L = 16, AW = 14, DW = 32;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [L-1:0] req_we = '0;
  logic [L*AW-1:0] req_addr = '0;
  logic [L*DW-1:0] req_wdata = '0;
  logic busy, done;
  logic [L*DW-1:0] rdata;

  banked_scratchpad uut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata));

  always #5 clk = ~clk;

  logic [31:0] model [16][256];
  logic [L-1:0] g_we;
  logic [AW-1:0] g_addr [L];
  logic [DW-1:0] g_wd [L];
  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_group(input int hold, input string tag);
    int cnt [16];
    int n;
    logic [31:0] exp_rd [L];
    for (int b = 0; b < 16; b++) cnt[b] = 0;
    for (int l = 0; l < L; l++) begin
      bit first = 1;
      for (int j = 0; j < l; j++)
        if (g_addr[j][13:2] == g_addr[l][13:2]) first = 0;
      if (first) cnt[g_addr[l][5:2]]++;
    end
    n = 1;
    for (int b = 0; b < 16; b++) if (cnt[b] > n) n = cnt[b];
    for (int l = 0; l < L; l++) exp_rd[l] = model[g_addr[l][5:2]][g_addr[l][13:6]];
    for (int l = 0; l < L; l++) if (g_we[l]) model[g_addr[l][5:2]][g_addr[l][13:6]] = g_wd[l];
    req_valid = 1'b1;
    req_we = g_we;
    for (int l = 0; l < L; l++) begin
      req_addr[l*AW +: AW] = g_addr[l];
      req_wdata[l*DW +: DW] = g_wd[l];
    end
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      if (k < hold) begin
        req_we = '1;
        for (int l = 0; l < L; l++) begin
          req_addr[l*AW +: AW] = {8'hFF, 4'(l), 2'b00};
          req_wdata[l*DW +: DW] = 32'hBAD0_0000 + l;
        end
      end else req_valid = 1'b0;
      check(busy === 1'b1, {"R2 busy in pass ", tag}, 32'(busy), 1);
      check(done === 1'b0, "R8 done during passes", 32'(done), 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(busy === 1'b0, {"R2 busy after last pass ", tag}, 32'(busy), 0);
    check(done === 1'b0, "R8 done early", 32'(done), 0);
    @(negedge clk);
    check(done === 1'b1, "R8 done pulse", 32'(done), 1);
    for (int l = 0; l < L; l++)
      check(rdata[l*DW +: DW] === exp_rd[l], {tag, " rdata lane"}, rdata[l*DW +: DW], exp_rd[l]);
    @(negedge clk);
    check(done === 1'b0, "R8 done single cycle", 32'(done), 0);
  endtask

  initial begin
    #1500000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R9 busy after reset", 32'(busy), 0);
    check(done === 1'b0, "R9 done after reset", 32'(done), 0);
    check(rdata === '0, "R9 rdata after reset", rdata[31:0], 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: fill every row with consecutive-word writes, one pass each
    for (int r = 0; r < 256; r++) begin
      g_we = '1;
      for (int l = 0; l < L; l++) begin
        g_addr[l] = {8'(r), 4'(l), 2'b00};
        g_wd[l] = {8'hA5, 8'(r), 8'(l), 8'h5A};
      end
      run_group(0, "R3");
    end
    // R3/R5: consecutive reads return stored words
    g_we = '0;
    for (int l = 0; l < L; l++) begin
      g_addr[l] = {8'd17, 4'(l), 2'b00};
      g_wd[l] = '0;
    end
    run_group(0, "R3 R5");
    // R2: four banks, four rows each -> four passes
    for (int l = 0; l < L; l++) g_addr[l] = {8'(l % 4), 4'(l / 4), 2'b00};
    run_group(0, "R2 four-way");
    // R2: all lanes one bank, 16 rows -> sixteen passes
    for (int l = 0; l < L; l++) g_addr[l] = {8'(l), 4'd0, 2'b00};
    run_group(0, "R2 sixteen-way");
    // R4: full broadcast
    for (int l = 0; l < L; l++) g_addr[l] = {8'd5, 4'd7, 2'b00};
    run_group(0, "R4 broadcast");
    // R4/R2: two words in one bank, eight readers each -> two passes
    for (int l = 0; l < L; l++) g_addr[l] = {(l < 8) ? 8'd1 : 8'd9, 4'd2, 2'b00};
    run_group(0, "R4 split broadcast");
    // R6/R5: lanes 3 and 12 write one word, lane 5 reads it
    for (int l = 0; l < L; l++) begin
      g_addr[l] = {8'd40, 4'(l), 2'b00};
      g_wd[l] = '0;
    end
    g_we = '0;
    g_we[3] = 1'b1;
    g_we[12] = 1'b1;
    g_addr[3] = {8'd20, 4'd6, 2'b00};
    g_addr[5] = {8'd20, 4'd6, 2'b00};
    g_addr[12] = {8'd20, 4'd6, 2'b00};
    g_wd[3] = 32'h3333_3333;
    g_wd[12] = 32'hCCCC_CCCC;
    run_group(0, "R5 R6");
    g_we = '0;
    for (int l = 0; l < L; l++) g_addr[l] = {8'd20, 4'd6, 2'(l)};
    run_group(0, "R6 winner");
    // R1: low address bits ignored on write, read back aligned
    g_we = '1;
    for (int l = 0; l < L; l++) begin
      g_addr[l] = {8'd77, 4'(15 - l), 2'b11};
      g_wd[l] = 32'h7700_0000 + l;
    end
    run_group(0, "R1");
    g_we = '0;
    for (int l = 0; l < L; l++) g_addr[l] = {8'd77, 4'(l), 2'b00};
    run_group(0, "R1 readback");
    // R7: requests held during a four-pass group are ignored
    for (int l = 0; l < L; l++) g_addr[l] = {8'(l % 4), 4'(l / 4), 2'b00};
    run_group(4, "R7 timing");
    for (int l = 0; l < L; l++) g_addr[l] = {8'hFF, 4'(l), 2'b00};
    run_group(0, "R7 memory");
    // random mixes with heavy conflicts
    for (int i = 0; i < 80; i++) begin
      for (int l = 0; l < L; l++) begin
        g_we[l] = 1'($urandom);
        g_addr[l] = {8'($urandom_range(0, 3)), 4'($urandom_range(0, 15)), 2'($urandom)};
        g_wd[l] = $urandom;
      end
      run_group(0, "R2 R5 R6 random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule